// File: doc/BRIEF.md
# Microcontroller Reset Sequencer

This block gathers every reset request of a small microcontroller into one active-high reset for the CPU and its peripherals. The requests are a power-on pulse, the level of the external reset pin (already brought into the clock domain), and three internal requests: watchdog timeout, low-voltage detect and illegal-address access. Power-on holds the reset for a stabilisation delay whose length is picked by a static option input. The reset is released only on a clock edge, and only once every request, the pin and all stretch timers have gone quiet.

The three internal requests also switch on an open-drain pulldown on the reset pin, so that devices outside the chip see the reset. The pulldown is stretched to a minimum length. Power-on never drives the pin. While the pulldown is on, the block ignores the pin, so its own pulldown cannot start a pin reset. A sticky cause register records which requests have fired since the last power-on or software clear.

Top module: `mcu_rst_combiner`

## Requirements
- R1: After `por_i` falls, `core_rst_o` stays high through the LEN-th rising edge and drops at edge LEN+1, where LEN is 16 when `long_delay_i` is 0 and 4064 when it is 1.
- R2: If the pin is still low when the power-on delay ends, `core_rst_o` stays high until the pin-reset condition ends.
- R3: If an internal request is still active when the power-on delay ends, `core_rst_o` stays high until that request and its pulldown stretch have ended.
- R4: A pin low must be sampled on 2 consecutive rising edges to count. A one-cycle low is ignored. A low sampled on edges 1..L (L ≥ 2) gives `core_rst_o` high after edges 3 through L+1.
- R5: An internal request sampled high on edges 1..n gives `pin_pull_o` high after edges 1 through n+3. A one-cycle request therefore pulls the pin for 4 cycles.
- R6: `pin_pull_o` never rises without an internal request on the previous edge. The power-on sequence never turns it on.
- R7: A pin sample taken while `pin_pull_o` is high is not counted as a pin low, and it cannot set the pin cause bit.
- R8: `cause_o` bits are: bit 0 power-on, bit 1 pin, bit 2 watchdog, bit 3 low-voltage, bit 4 illegal address. Power-on leaves exactly 5'b00001. Each request sets its own bit, and bits stay set until cleared.
- R9: `cause_clr_i` sampled high clears every bit. A request sampled on the same edge is still recorded.
- R10: `core_rst_o` falls only on a clock edge, one cycle after the last of the power-on delay, pin condition, request and pulldown stretch has ended.
- R11: An internal request sampled on an edge makes `core_rst_o` high after that same edge. With a request sampled on edges 1..n, `core_rst_o` is high after edges 1 through n+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| long_delay_i | input | 1 | Static option: 1 selects the long stabilisation delay |
| pin_n_i | input | 1 | Synchronised reset pin level, low requests reset |
| wdog_req_i | input | 1 | Watchdog timeout request |
| lowv_req_i | input | 1 | Low-voltage request |
| badaddr_req_i | input | 1 | Illegal-address request |
| cause_clr_i | input | 1 | Clears the sticky cause register |
| core_rst_o | output | 1 | Internal reset, active high |
| pin_pull_o | output | 1 | Enable for the reset-pin pulldown |
| cause_o | output | 5 | Sticky reset-cause flags |

## Verification
The bench sweeps request lengths 1 to 6 for each internal source and pin lows of 1 to 5 cycles. A stretch counter that is off by one, or that ignores a held request, shows up as a pulldown or reset that is one cycle short or long. It also holds the pin low while the block's own pulldown is on, and one cycle past it. A design without the mask would start a pin reset there and set the pin cause bit. Power-on runs both delay lengths and overlaps the end of the delay with a low pin and with a held watchdog request. A sequencer that lets go when its timer expires would drop the reset too early. A clear raised on the same edge as a new request checks that the request is not lost.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int unsigned NUM_PULL_SRC = 3;
  localparam int unsigned NUM_CAUSE    = 5;

  localparam int unsigned CAUSE_POR       = 0;
  localparam int unsigned CAUSE_PIN       = 1;
  localparam int unsigned CAUSE_FIRST_SRC = 2;

  // Stabilisation length chosen by the static option bit.
  function automatic int unsigned por_hold_len(input logic long_sel,
                                               input int unsigned short_len,
                                               input int unsigned long_len);
    return long_sel ? long_len : short_len;
  endfunction

  // Next value of the pulldown stretch counter.
  function automatic int unsigned stretch_next(input logic src_any,
                                               input int unsigned cur,
                                               input int unsigned hold);
    if (src_any) return hold;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

  // Next value of the pin-low qualification counter (saturating).
  function automatic int unsigned qual_next(input logic low_seen,
                                            input int unsigned cur,
                                            input int unsigned qual);
    if (!low_seen) return 0;
    if (cur >= qual) return qual;
    return cur + 1;
  endfunction
endpackage

// File: rtl/rstc_por_timer.sv
module rstc_por_timer #(
  parameter int unsigned SHORT_LEN = 16,
  parameter int unsigned LONG_LEN  = 4064
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic long_sel_i,
  output logic busy_o
);
  localparam int unsigned MAX_LEN = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
  localparam int unsigned CW      = $clog2(MAX_LEN + 1);

  logic [CW-1:0] elapsed_q;
  logic [CW-1:0] limit;

  assign limit  = CW'(rstc_pkg::por_hold_len(long_sel_i, SHORT_LEN, LONG_LEN));
  assign busy_o = (elapsed_q < limit);

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      elapsed_q <= '0;
    end else if (busy_o) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end
endmodule

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
  parameter int unsigned QUAL = 2
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic pin_n_i,
  input  logic mask_i,
  output logic low_seen_o,
  output logic active_o
);
  localparam int unsigned QW = $clog2(QUAL + 1);

  logic [QW-1:0] low_cnt_q;
  logic [QW-1:0] low_cnt_d;

  assign low_seen_o = !pin_n_i && !mask_i;
  assign low_cnt_d  = QW'(rstc_pkg::qual_next(low_seen_o, int'(low_cnt_q), QUAL));
  assign active_o   = (low_cnt_q >= QW'(QUAL));

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      low_cnt_q <= '0;
    end else begin
      low_cnt_q <= low_cnt_d;
    end
  end
endmodule

// File: rtl/rstc_pull_stretch.sv
module rstc_pull_stretch #(
  parameter int unsigned NSRC = 3,
  parameter int unsigned HOLD = 4
) (
  input  logic            clk_i,
  input  logic            por_i,
  input  logic [NSRC-1:0] src_i,
  output logic            src_any_o,
  output logic            pull_o
);
  localparam int unsigned HW = $clog2(HOLD + 1);

  logic [NSRC:0]  or_chain;
  logic [HW-1:0]  hold_q;
  logic [HW-1:0]  hold_d;

  assign or_chain[0] = 1'b0;
  for (genvar i = 0; i < NSRC; i++) begin : g_or
    assign or_chain[i+1] = or_chain[i] | src_i[i];
  end

  assign src_any_o = or_chain[NSRC];
  assign hold_d    = HW'(rstc_pkg::stretch_next(src_any_o, int'(hold_q), HOLD));
  assign pull_o    = (hold_q != '0);

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end
endmodule

// File: rtl/rstc_cause_log.sv
module rstc_cause_log
  import rstc_pkg::*;
#(
  parameter int unsigned NSRC = NUM_PULL_SRC
) (
  input  logic                 clk_i,
  input  logic                 por_i,
  input  logic                 pin_evt_i,
  input  logic [NSRC-1:0]      src_i,
  input  logic                 clr_i,
  output logic [NUM_CAUSE-1:0] cause_o
);
  localparam logic [NUM_CAUSE-1:0] POR_ONLY = NUM_CAUSE'(1) << CAUSE_POR;

  logic [NUM_CAUSE-1:0] set_vec;
  logic [NUM_CAUSE-1:0] cause_q;

  assign set_vec[CAUSE_POR] = 1'b0;
  assign set_vec[CAUSE_PIN] = pin_evt_i;
  for (genvar i = 0; i < NSRC; i++) begin : g_set
    assign set_vec[CAUSE_FIRST_SRC + i] = src_i[i];
  end

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      cause_q <= POR_ONLY;
    end else if (clr_i) begin
      cause_q <= set_vec;
    end else begin
      cause_q <= cause_q | set_vec;
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/mcu_rst_combiner.sv
module mcu_rst_combiner
  import rstc_pkg::*;
#(
  parameter int unsigned SHORT_DELAY = 16,
  parameter int unsigned LONG_DELAY  = 4064,
  parameter int unsigned PIN_QUAL    = 2,
  parameter int unsigned PULL_HOLD   = 4
) (
  input  logic                 clk_i,
  input  logic                 por_i,
  input  logic                 long_delay_i,
  input  logic                 pin_n_i,
  input  logic                 wdog_req_i,
  input  logic                 lowv_req_i,
  input  logic                 badaddr_req_i,
  input  logic                 cause_clr_i,
  output logic                 core_rst_o,
  output logic                 pin_pull_o,
  output logic [NUM_CAUSE-1:0] cause_o
);
  // Named internal events, visible to the bound checker.
  logic                    por_busy;
  logic                    pin_low_seen;
  logic                    pin_active;
  logic [NUM_PULL_SRC-1:0] src_vec;
  logic                    src_any;
  logic                    rst_cond;
  logic                    core_rst_q;

  assign src_vec = {badaddr_req_i, lowv_req_i, wdog_req_i};

  rstc_por_timer #(
    .SHORT_LEN (SHORT_DELAY),
    .LONG_LEN  (LONG_DELAY)
  ) u_por (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .long_sel_i (long_delay_i),
    .busy_o     (por_busy)
  );

  rstc_pull_stretch #(
    .NSRC (NUM_PULL_SRC),
    .HOLD (PULL_HOLD)
  ) u_pull (
    .clk_i     (clk_i),
    .por_i     (por_i),
    .src_i     (src_vec),
    .src_any_o (src_any),
    .pull_o    (pin_pull_o)
  );

  rstc_pin_filter #(
    .QUAL (PIN_QUAL)
  ) u_pin (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .pin_n_i    (pin_n_i),
    .mask_i     (pin_pull_o),
    .low_seen_o (pin_low_seen),
    .active_o   (pin_active)
  );

  rstc_cause_log #(
    .NSRC (NUM_PULL_SRC)
  ) u_cause (
    .clk_i     (clk_i),
    .por_i     (por_i),
    .pin_evt_i (pin_active),
    .src_i     (src_vec),
    .clr_i     (cause_clr_i),
    .cause_o   (cause_o)
  );

  assign rst_cond = por_busy | pin_active | src_any | pin_pull_o;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      core_rst_q <= 1'b1;
    end else begin
      core_rst_q <= rst_cond;
    end
  end

  assign core_rst_o = core_rst_q;
endmodule

// File: rtl/mcu_rst_combiner_chk.sv
module mcu_rst_combiner_chk
  import rstc_pkg::*;
(
  input logic                 clk_i,
  input logic                 por_i,
  input logic                 por_busy,
  input logic                 pin_active,
  input logic                 src_any,
  input logic                 pin_pull_o,
  input logic                 core_rst_o,
  input logic                 cause_clr_i,
  input logic [NUM_CAUSE-1:0] cause_o
);
  a_r6_pull_needs_src: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(pin_pull_o) |-> $past(src_any));

  a_r5_pull_follows_src: assert property (@(posedge clk_i) disable iff (por_i)
    src_any |=> pin_pull_o);

  a_r5_pull_min_span: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(pin_pull_o) |-> (!$past(src_any, 1) && !$past(src_any, 2) &&
                           !$past(src_any, 3) && !$past(src_any, 4)));

  a_r10_release_sync: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(core_rst_o) |-> $past(!(por_busy || pin_active || src_any || pin_pull_o)));

  a_r7_pin_masked: assert property (@(posedge clk_i) disable iff (por_i)
    (pin_pull_o && !pin_active) |=> !pin_active);

  a_r4_pin_holds_rst: assert property (@(posedge clk_i) disable iff (por_i)
    pin_active |=> core_rst_o);

  a_r9_clear_drops_por: assert property (@(posedge clk_i) disable iff (por_i)
    cause_clr_i |=> !cause_o[CAUSE_POR]);

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (por_i)
    !cause_clr_i |=> ((cause_o & $past(cause_o)) == $past(cause_o)));
endmodule

bind mcu_rst_combiner mcu_rst_combiner_chk u_chk (
  .clk_i       (clk_i),
  .por_i       (por_i),
  .por_busy    (por_busy),
  .pin_active  (pin_active),
  .src_any     (src_any),
  .pin_pull_o  (pin_pull_o),
  .core_rst_o  (core_rst_o),
  .cause_clr_i (cause_clr_i),
  .cause_o     (cause_o)
);

// File: tb/mcu_rst_combiner_tb.sv
module mcu_rst_combiner_tb;
  localparam int SHORT_D = 16;
  localparam int LONG_D  = 4064;
  localparam int QUAL    = 2;
  localparam int HOLD    = 4;

  logic       clk = 1'b0;
  logic       por, lng, pin_n, clr;
  logic [2:0] src_drv;
  logic       core_rst, pull;
  logic [4:0] cause;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  mcu_rst_combiner u_dut (
    .clk_i         (clk),
    .por_i         (por),
    .long_delay_i  (lng),
    .pin_n_i       (pin_n),
    .wdog_req_i    (src_drv[0]),
    .lowv_req_i    (src_drv[1]),
    .badaddr_req_i (src_drv[2]),
    .cause_clr_i   (clr),
    .core_rst_o    (core_rst),
    .pin_pull_o    (pull),
    .cause_o       (cause)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start_por(input logic long_sel);
    lng = long_sel;
    por = 1'b1;
    tick();
    por = 1'b0;
  endtask

  task automatic settle_por();
    start_por(1'b0);
    repeat (SHORT_D + 2) tick();
    clr = 1'b1;
    tick();
    clr = 1'b0;
  endtask

  // Expected values from the requirements.
  function automatic int exp_src_pull(int n, int t);
    return (t <= n + HOLD - 1) ? 1 : 0;
  endfunction
  function automatic int exp_src_rst(int n, int t);
    return (t <= n + HOLD) ? 1 : 0;
  endfunction
  function automatic int exp_pin_rst(int len, int t);
    return (len >= QUAL && t >= QUAL + 1 && t <= len + 1) ? 1 : 0;
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    por = 1'b1; lng = 1'b0; pin_n = 1'b1; clr = 1'b0; src_drv = '0;
    @(negedge clk);
    tick();
    check("R8 reset core_rst", int'(core_rst), 1);
    check("R6 reset pull", int'(pull), 0);
    check("R8 reset cause", int'(cause), 5'b00001);

    // R1: both delay lengths, R6 pull never on during power-on
    for (int sel = 0; sel < 2; sel++) begin
      int len;
      len = (sel == 1) ? LONG_D : SHORT_D;
      start_por(logic'(sel));
      for (int k = 1; k <= len + 1; k++) begin
        tick();
        if (pull !== 1'b0) check("R6 pull during por", int'(pull), 0);
        if (k == len)      check("R1 rst held at LEN", int'(core_rst), 1);
        if (k == len + 1)  check("R1 rst released LEN+1", int'(core_rst), 0);
      end
      check("R6 no pull after por", int'(pull), 0);
      check("R8 cause after por", int'(cause), 5'b00001);
    end

    // R2: pin still low when the delay ends
    pin_n = 1'b0;
    start_por(1'b0);
    for (int k = 1; k <= SHORT_D + 7; k++) begin
      tick();
      if (k == SHORT_D + 5) pin_n = 1'b1;
      if (k == SHORT_D + 1) check("R2 rst extended by pin", int'(core_rst), 1);
      if (k == SHORT_D + 6) check("R2 rst last cycle", int'(core_rst), 1);
      if (k == SHORT_D + 7) check("R2 rst released", int'(core_rst), 0);
    end
    check("R2 cause por+pin", int'(cause), 5'b00011);

    // R3: watchdog still active when the delay ends
    src_drv = 3'b001;
    start_por(1'b0);
    for (int k = 1; k <= SHORT_D + 7; k++) begin
      int m;
      m = SHORT_D + 2;
      tick();
      if (k == m) src_drv = 3'b000;
      if (k == SHORT_D + 1) check("R3 rst extended by source", int'(core_rst), 1);
      if (k == m + 3) check("R3 pull last cycle", int'(pull), 1);
      if (k == m + 4) check("R3 pull off / rst on", int'({pull, core_rst}), 2'b01);
      if (k == m + 5) check("R3 rst released", int'(core_rst), 0);
    end
    check("R3 cause por+wdog", int'(cause), 5'b00101);

    settle_por();
    check("R9 clear empties causes", int'(cause), 5'b00000);

    // R5, R8, R10, R11: every source, request lengths 1..6
    for (int s = 0; s < 3; s++) begin
      for (int n = 1; n <= 6; n++) begin
        src_drv = 3'(1 << s);
        for (int t = 1; t <= n + HOLD + 1; t++) begin
          tick();
          if (t == n) src_drv = '0;
          check($sformatf("R5 pull src%0d n%0d t%0d", s, n, t), int'(pull), exp_src_pull(n, t));
          check($sformatf("R11/R10 rst src%0d n%0d t%0d", s, n, t), int'(core_rst), exp_src_rst(n, t));
        end
        check($sformatf("R8 cause src%0d", s), int'(cause), 1 << (2 + s));
        clr = 1'b1;
        tick();
        clr = 1'b0;
      end
    end

    // R4: pin lows of 1..5 cycles
    for (int len = 1; len <= 5; len++) begin
      pin_n = 1'b0;
      for (int t = 1; t <= len + 3; t++) begin
        tick();
        if (t == len) pin_n = 1'b1;
        check($sformatf("R4 rst pin len%0d t%0d", len, t), int'(core_rst), exp_pin_rst(len, t));
        if (pull !== 1'b0) check("R6 pin causes no pull", int'(pull), 0);
      end
      check($sformatf("R8 pin cause len%0d", len), int'(cause), (len >= QUAL) ? 5'b00010 : 0);
      clr = 1'b1;
      tick();
      clr = 1'b0;
    end

    // R7: own pulldown seen on the pin, lagging one cycle past it
    src_drv = 3'b001;
    for (int t = 1; t <= 8; t++) begin
      tick();
      if (t == 1) begin src_drv = '0; pin_n = 1'b0; end
      if (t == 5) pin_n = 1'b1;
      check($sformatf("R7 rst masked t%0d", t), int'(core_rst), exp_src_rst(1, t));
    end
    check("R7 no pin cause from own pulldown", int'(cause), 5'b00100);
    clr = 1'b1;
    tick();
    clr = 1'b0;

    // R8 sticky accumulation
    src_drv = 3'b001; tick(); src_drv = 3'b000; tick();
    src_drv = 3'b010; tick(); src_drv = 3'b000;
    repeat (8) tick();
    check("R8 sticky wdog+lowv", int'(cause), 5'b01100);

    // R9 clear on the same edge as a new request
    clr = 1'b1; src_drv = 3'b100;
    tick();
    clr = 1'b0; src_drv = 3'b000;
    check("R9 clear keeps new request", int'(cause), 5'b10000);
    repeat (8) tick();
    check("R10 idle after clear test", int'(core_rst), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule